// File: doc/BRIEF.md
# Power-of-Two Burst Request Splitter

This block sits between a transfer engine and an external-memory controller that drives a 16-bit parallel device bus. It accepts one transfer request, made of a start word address and a length in bytes, and turns it into a short series of fixed-length burst descriptors. Each burst length is a power of two in words, from two words up to one device page of 32 words. The splitting mimics the way a system interconnect breaks up traffic for such a controller. A device on the far side can therefore predict exactly how many fragments will arrive and in what order.

The byte length is first rounded up to whole words. An odd word count is then rounded up to the next even value. Each set bit of that rounded count produces one burst, and the bursts are issued from the largest to the smallest. At the moment a request is accepted, the block shows the number of bursts it will produce. When the last burst has been taken, it reports how many bursts were actually issued. A request of zero bytes, or of more than one page, is refused with an error pulse and produces no bursts. Reads and writes are split the same way, so the block carries no direction bit.

Top module: `burst_splitter`

## Requirements
- R1: The rounded word count is ceil(bytes/4)*2. Odd byte counts round up to a whole 2-byte word, and odd word counts round up to an even count. For example, 10 bytes give 6 words, 14 bytes give 8 words and 62 bytes give 32 words.
- R2: One burst is issued for each set bit of the rounded count. Bit k gives a burst of 2^k words, for k from 1 to 5. Bursts are issued in descending size, and `bst_words` is a one-hot word count.
- R3: The first burst address equals `req_addr`. Each later burst address is the previous address plus the previous burst length, in words.
- R4: `bst_last` is high on the final burst of a request and low on every earlier burst.
- R5: While idle with `req_valid` high, `exp_count` equals the number of set bits in the rounded count. It reads 0 for a rejected length.
- R6: A request of 0 bytes, or of more than 64 bytes, is accepted and then refused. `req_err` is high for exactly the one cycle after acceptance, and no burst is issued.
- R7: `req_ready` is low from the cycle after a good request is accepted until the cycle after its last burst is taken.
- R8: While `bst_valid` is high and `bst_ready` is low, `bst_addr`, `bst_words` and `bst_last` hold their values.
- R9: `sts_valid` pulses for one cycle, in the cycle after the last burst is taken. During that pulse, `sts_bursts` equals the number of bursts issued.
- R10: After reset, `req_ready` is 1 and `bst_valid`, `sts_valid` and `req_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and takes the request |
| req_addr | input | ADDR_W | Start word address |
| req_bytes | input | LEN_W | Transfer length in bytes |
| req_err | output | 1 | One-cycle pulse: the accepted length was refused |
| exp_count | output | CNT_W | Burst count the offered request will produce |
| bst_valid | output | 1 | Burst descriptor offered |
| bst_ready | input | 1 | Downstream takes the descriptor |
| bst_addr | output | ADDR_W | Burst start word address |
| bst_words | output | WCNT_W | Burst length in words (one-hot) |
| bst_last | output | 1 | Final burst of the request |
| sts_valid | output | 1 | One-cycle pulse when a request completes |
| sts_bursts | output | CNT_W | Bursts issued by the completed request |

## Verification
The bench sweeps every byte length from 0 to 72, plus the top of the length range. It runs each length at several start addresses and under several downstream stall patterns, and compares every descriptor against a split it computes itself. The sweep targets the lengths that sit one word below a power of two, such as 14, 30 and 62 bytes. A design that skipped the round-up would split these into many small bursts instead of one. Stalls that fall on the last burst catch a block that drops `bst_last`, reopens `req_ready` early or pulses the status twice. The 0 and 65-byte cases catch a block that issues a zero-length or oversized burst instead of raising `req_err`.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Result of decoding one request length.
    typedef struct packed {
        logic        ok;       // length inside 1..page bytes
        logic [15:0] rwords;   // even-rounded word count
    } len_dec_t;

    // Population count of a 32-bit vector.
    function automatic logic [5:0] ones32(input logic [31:0] v);
        logic [5:0] c;
        c = '0;
        for (int i = 0; i < 32; i++) begin
            c = c + 6'(v[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/bsp_len_decode.sv
module bsp_len_decode
    import bsp_pkg::*;
#(
    parameter int LEN_W          = 8,
    parameter int BYTES_PER_WORD = 2,
    parameter int PAGE_WORDS     = 32,
    parameter int WCNT_W         = 6,
    parameter int CNT_W          = 3
) (
    input  logic [LEN_W-1:0]  bytes_i,
    output logic              ok_o,
    output logic [WCNT_W-1:0] rwords_o,
    output logic [CNT_W-1:0]  nbursts_o
);
    localparam int PAIR_BYTES = 2 * BYTES_PER_WORD;
    localparam int PAIR_SH    = $clog2(PAIR_BYTES);
    localparam int MAX_BYTES  = PAGE_WORDS * BYTES_PER_WORD;

    logic [LEN_W:0] padded;
    logic [LEN_W:0] pairs;
    len_dec_t       dec;

    always_comb begin
        padded     = {1'b0, bytes_i} + (LEN_W+1)'(PAIR_BYTES - 1);
        pairs      = padded >> PAIR_SH;
        dec.ok     = (bytes_i != '0) && (32'(bytes_i) <= 32'(MAX_BYTES));
        dec.rwords = dec.ok ? 16'({pairs, 1'b0}) : 16'd0;
        ok_o       = dec.ok;
        rwords_o   = dec.rwords[WCNT_W-1:0];
        nbursts_o  = CNT_W'(ones32(32'(dec.rwords)));
    end
endmodule

// File: rtl/bsp_msb_pick.sv
module bsp_msb_pick #(
    parameter int W = 6
) (
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] pick_o
);
    logic [W:0] above;

    assign above[W] = 1'b0;

    generate
        for (genvar i = W - 1; i >= 0; i--) begin : g_bit
            assign above[i]  = above[i+1] | mask_i[i];
            assign pick_o[i] = mask_i[i] & ~above[i+1];
        end
    endgenerate
endmodule

// File: rtl/bsp_sequencer.sv
module bsp_sequencer
    import bsp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WCNT_W = 6,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              len_ok,
    input  logic [WCNT_W-1:0] len_rwords,
    output logic              req_err,
    output logic              bst_valid,
    input  logic              bst_ready,
    output logic [ADDR_W-1:0] bst_addr,
    output logic [WCNT_W-1:0] bst_words,
    output logic              bst_last,
    output logic              sts_valid,
    output logic [CNT_W-1:0]  sts_bursts
);
    seq_state_e        state;
    logic [WCNT_W-1:0] mask;
    logic [WCNT_W-1:0] pick;
    logic [WCNT_W-1:0] rest;
    logic [ADDR_W-1:0] addr;
    logic [CNT_W-1:0]  issued;

    bsp_msb_pick #(.W(WCNT_W)) u_pick (
        .mask_i (mask),
        .pick_o (pick)
    );

    assign rest      = mask & ~pick;
    assign req_ready = (state == SEQ_IDLE);
    assign bst_valid = (state == SEQ_RUN);
    assign bst_addr  = addr;
    assign bst_words = pick;
    assign bst_last  = (rest == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SEQ_IDLE;
            mask       <= '0;
            addr       <= '0;
            issued     <= '0;
            req_err    <= 1'b0;
            sts_valid  <= 1'b0;
            sts_bursts <= '0;
        end else begin
            req_err   <= 1'b0;
            sts_valid <= 1'b0;
            unique case (state)
                SEQ_IDLE: begin
                    if (req_valid) begin
                        if (!len_ok) begin
                            req_err <= 1'b1;
                        end else begin
                            mask   <= len_rwords;
                            addr   <= req_addr;
                            issued <= '0;
                            state  <= SEQ_RUN;
                        end
                    end
                end
                SEQ_RUN: begin
                    if (bst_ready) begin
                        mask   <= rest;
                        addr   <= addr + ADDR_W'(pick);
                        issued <= issued + 1'b1;
                        if (rest == '0) begin
                            state      <= SEQ_IDLE;
                            sts_valid  <= 1'b1;
                            sts_bursts <= issued + 1'b1;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/burst_splitter.sv
module burst_splitter
    import bsp_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter int LEN_W          = 8,
    parameter int BYTES_PER_WORD = 2,
    parameter int PAGE_WORDS     = 32,
    localparam int WCNT_W        = $clog2(PAGE_WORDS) + 1,
    localparam int CNT_W         = $clog2(WCNT_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_bytes,
    output logic              req_err,
    output logic [CNT_W-1:0]  exp_count,
    output logic              bst_valid,
    input  logic              bst_ready,
    output logic [ADDR_W-1:0] bst_addr,
    output logic [WCNT_W-1:0] bst_words,
    output logic              bst_last,
    output logic              sts_valid,
    output logic [CNT_W-1:0]  sts_bursts
);
    logic              len_ok;
    logic [WCNT_W-1:0] len_rwords;

    bsp_len_decode #(
        .LEN_W          (LEN_W),
        .BYTES_PER_WORD (BYTES_PER_WORD),
        .PAGE_WORDS     (PAGE_WORDS),
        .WCNT_W         (WCNT_W),
        .CNT_W          (CNT_W)
    ) u_dec (
        .bytes_i   (req_bytes),
        .ok_o      (len_ok),
        .rwords_o  (len_rwords),
        .nbursts_o (exp_count)
    );

    bsp_sequencer #(
        .ADDR_W (ADDR_W),
        .WCNT_W (WCNT_W),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .len_ok     (len_ok),
        .len_rwords (len_rwords),
        .req_err    (req_err),
        .bst_valid  (bst_valid),
        .bst_ready  (bst_ready),
        .bst_addr   (bst_addr),
        .bst_words  (bst_words),
        .bst_last   (bst_last),
        .sts_valid  (sts_valid),
        .sts_bursts (sts_bursts)
    );
endmodule

// File: rtl/bsp_checker.sv
module bsp_checker #(
    parameter int ADDR_W = 32,
    parameter int WCNT_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              req_err,
    input logic              bst_valid,
    input logic              bst_ready,
    input logic [ADDR_W-1:0] bst_addr,
    input logic [WCNT_W-1:0] bst_words,
    input logic              bst_last,
    input logic              sts_valid
);
    // R8: descriptor held while stalled
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (bst_valid && !bst_ready) |=> (bst_valid && $stable(bst_addr)
                                       && $stable(bst_words) && $stable(bst_last)));

    // R2: every burst is a single power of two of at least two words
    p_pow2_r2: assert property (@(posedge clk) disable iff (rst)
        bst_valid |-> ($countones(bst_words) == 1 && !bst_words[0]));

    // R2: sizes strictly descend inside a request
    p_desc_r2: assert property (@(posedge clk) disable iff (rst)
        (bst_valid && bst_ready && !bst_last) |=>
            (bst_valid && bst_words < $past(bst_words)));

    // R3: next address follows the previous burst
    p_addr_r3: assert property (@(posedge clk) disable iff (rst)
        (bst_valid && bst_ready && !bst_last) |=>
            (bst_addr == $past(bst_addr) + ADDR_W'($past(bst_words))));

    // R7: no new request taken while bursts are pending
    p_busy_r7: assert property (@(posedge clk) disable iff (rst)
        bst_valid |-> !req_ready);

    // R9: completion pulse follows the last handshake
    p_sts_r9: assert property (@(posedge clk) disable iff (rst)
        (bst_valid && bst_ready && bst_last) |=> (sts_valid && !bst_valid));

    // R6: a refused request issues nothing
    p_err_r6: assert property (@(posedge clk) disable iff (rst)
        req_err |-> (!bst_valid && req_ready));
endmodule

bind burst_splitter bsp_checker #(
    .ADDR_W (ADDR_W),
    .WCNT_W (WCNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .req_err   (req_err),
    .bst_valid (bst_valid),
    .bst_ready (bst_ready),
    .bst_addr  (bst_addr),
    .bst_words (bst_words),
    .bst_last  (bst_last),
    .sts_valid (sts_valid)
);

// File: tb/burst_splitter_bench.sv
module burst_splitter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int LEN_W      = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_bytes = '0;
    logic              req_err;
    logic [2:0]        exp_count;
    logic              bst_valid;
    logic              bst_ready = 1'b0;
    logic [ADDR_W-1:0] bst_addr;
    logic [5:0]        bst_words;
    logic              bst_last;
    logic              sts_valid;
    logic [2:0]        sts_bursts;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_splitter u_burst_splitter (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_bytes(req_bytes),
        .req_err(req_err), .exp_count(exp_count),
        .bst_valid(bst_valid), .bst_ready(bst_ready),
        .bst_addr(bst_addr), .bst_words(bst_words), .bst_last(bst_last),
        .sts_valid(sts_valid), .sts_bursts(sts_bursts)
    );

    task automatic chk(input bit cond, input string req, input longint act, input longint exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rounded(input int b);
        return ((b + 3) / 4) * 2;
    endfunction

    function automatic int ones(input int v);
        int c = 0;
        for (int i = 0; i < 8; i++) c += (v >> i) & 1;
        return c;
    endfunction

    function automatic int top_bit(input int v);
        int p = 0;
        for (int i = 0; i < 8; i++) if ((v >> i) & 1) p = 1 << i;
        return p;
    endfunction

    task automatic run_req(input int addr, input int b, input int mode);
        bit good;
        int rem, cur, nb, cyc;
        bit stalled;
        int s_addr, s_words, s_last;
        good = (b >= 1) && (b <= 64);
        rem  = good ? rounded(b) : 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = ADDR_W'(addr);
        req_bytes = LEN_W'(b);
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        // R5: expected fragment count while offered
        chk(exp_count == 3'(ones(rem)), "R5 exp_count", exp_count, ones(rem));
        @(negedge clk);
        req_valid = 1'b0;
        if (!good) begin
            // R6: refusal pulse and no burst
            chk(req_err == 1'b1, "R6 req_err pulse", req_err, 1);
            chk(bst_valid == 1'b0, "R6 no burst", bst_valid, 0);
            @(negedge clk);
            chk(req_err == 1'b0 && bst_valid == 1'b0, "R6 pulse width", req_err, 0);
            return;
        end
        chk(req_err == 1'b0, "R6 no error on good length", req_err, 0);
        cur = addr; nb = 0; cyc = 0; stalled = 1'b0;
        s_addr = 0; s_words = 0; s_last = 0;
        while (rem != 0 && cyc < 200) begin
            if (stalled) begin
                // R8: stalled descriptor holds
                chk(int'(bst_addr) == s_addr && int'(bst_words) == s_words
                    && int'(bst_last) == s_last, "R8 hold", bst_words, s_words);
            end
            bst_ready = (mode == 0) ? 1'b1 : ((cyc % (mode + 1)) != 0);
            chk(bst_valid == 1'b1, "R2 burst offered", bst_valid, 1);
            // R7: no request taken while busy
            chk(req_ready == 1'b0, "R7 busy", req_ready, 0);
            if (bst_ready) begin
                // R1/R2: size from the rounded count, largest first
                chk(int'(bst_words) == top_bit(rem), "R1 R2 burst words", bst_words, top_bit(rem));
                // R3: address
                chk(int'(bst_addr) == cur, "R3 burst addr", bst_addr, cur);
                // R4: last marker
                chk(bst_last == (rem == top_bit(rem)), "R4 last", bst_last, rem == top_bit(rem));
                cur += top_bit(rem);
                rem -= top_bit(rem);
                nb++;
                stalled = 1'b0;
            end else begin
                stalled = 1'b1;
                s_addr  = int'(bst_addr);
                s_words = int'(bst_words);
                s_last  = int'(bst_last);
            end
            cyc++;
            @(negedge clk);
        end
        bst_ready = 1'b0;
        // R9: completion status
        chk(sts_valid == 1'b1, "R9 sts_valid", sts_valid, 1);
        chk(int'(sts_bursts) == nb, "R9 sts_bursts", sts_bursts, nb);
        chk(req_ready == 1'b1 && bst_valid == 1'b0, "R7 ready after last", req_ready, 1);
        @(negedge clk);
        chk(sts_valid == 1'b0, "R9 pulse width", sts_valid, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R10: reset state
        chk(req_ready == 1'b1, "R10 req_ready", req_ready, 1);
        chk(bst_valid == 1'b0 && sts_valid == 1'b0 && req_err == 1'b0,
            "R10 outputs idle", bst_valid, 0);
        for (int b = 0; b <= 72; b++) begin
            for (int m = 0; m < 3; m++) begin
                run_req(32'h100 * b + m * 7, b, m);
            end
        end
        run_req(32'hFFFF_FFF0, 62, 1);
        run_req(32'h40, 255, 0);
        run_req(32'h44, 65, 2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule